// File: doc/BRIEF.md
# Resumable Serial Register Write Port

This block is the receiving end of a serial interface used to load configuration words into a converter. A host shifts a 24-bit word in, most significant bit first, over a serial clock and data line. An active-low frame strobe marks when the bits count. The host may raise the strobe partway through a word. The bits received so far are kept, and the word carries on from the next bit when the strobe goes low again. All pins are asynchronous to the block. Each pin passes through its own synchroniser stages, and the serial clock edges are then found in the system clock domain.

A destination pin chooses where a finished word goes. At 0 it goes to the control register. At 1 it goes to one of three calibration registers, and a 2-bit select input picks which one. Every register is written in one step on the system clock cycle after the last bit is captured. A one-cycle done pulse is raised on that same cycle. Reset is asynchronous and active low. Its release is synchronised inside the block.

Top module: `serial_reg_write_port`

## Requirements
- R1: While reset is asserted, and after it is released, the control register, the three calibration registers and the done pulse are all zero, and the next word starts at its first bit.
- R2: The first bit captured in a word lands in bit 23 of the target register, and the 24th bit lands in bit 0.
- R3: A word completed with the destination pin at 0 is written to the control register, and no calibration register changes.
- R4: A word completed with the destination pin at 1 is written to a calibration register chosen by the select input: 0 = zero-scale, 1 = full-scale, 2 = spare. No other register changes.
- R5: A word completed with the destination pin at 1 and the select input at 3 changes no register, but the done pulse is still raised.
- R6: A bit is taken only on a rising serial clock edge seen while the frame strobe is low. Edges seen while the strobe is high change neither the stored bits nor the count.
- R7: Raising the frame strobe mid-word holds the bit count and the bits already received. After the strobe goes low again, capture resumes with the next bit of the word.
- R8: The target register and the done pulse update together on the cycle after the 24th bit is captured. This is SYNC_STAGES+2 system clock cycles after the serial clock rises at the pin. The done pulse lasts exactly one cycle.
- R9: After the 24th bit the bit count returns to zero, so a following word is assembled from its own first bit.
- R10: Each bit takes the data value present at the rising serial clock edge. A change on the data line later in the same high phase has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial clock from the host, asynchronous |
| sdata_in | input | 1 | Serial data, MSB first |
| frame_n_in | input | 1 | Active-low frame strobe |
| dest_in | input | 1 | Destination: 0 control, 1 calibration |
| cal_sel_in | input | 2 | Calibration register select |
| ctrl_reg_o | output | 24 | Control register |
| cal_zero_o | output | 24 | Zero-scale calibration register |
| cal_full_o | output | 24 | Full-scale calibration register |
| cal_spare_o | output | 24 | Spare calibration register |
| wr_done_o | output | 1 | One-cycle pulse when a word is committed |

## Verification
The bench builds the block with its defaults: a 24-bit word and two synchroniser stages per pin. Two stages make the commit latency exactly four system cycles after the serial clock rises, and the bench measures that value directly. With a serial half period of only a few system cycles, the bench can cover many things within a short run. It raises the strobe at random bit positions. It sends spurious clock pulses while the strobe is high, and changes the data line late in a high phase. It also sends back-to-back words to every destination, including the unused select code.

// File: rtl/srw_pkg.sv
package srw_pkg;
  localparam int unsigned CAL_NUM   = 3;
  localparam int unsigned CAL_SEL_W = 2;

  typedef enum logic [CAL_SEL_W-1:0] {
    CAL_ZERO  = 2'd0,
    CAL_FULL  = 2'd1,
    CAL_SPARE = 2'd2,
    CAL_NONE  = 2'd3
  } cal_slot_e;

  typedef struct packed {
    logic                 commit;
    logic                 dest;
    logic [CAL_SEL_W-1:0] sel;
  } commit_req_t;
endpackage

// File: rtl/srw_sync.sv
module srw_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/srw_shifter.sv
module srw_shifter #(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sdata_s,
  input  logic              frame_n_s,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              word_rdy_o
);
  logic              sclk_prev_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic              rdy_q, rdy_d;
  logic              take_bit;
  logic              last_bit;

  assign take_bit = sclk_s & ~sclk_prev_q & ~frame_n_s;
  assign last_bit = (cnt_q == CNT_W'(WORD_W - 1));

  always_comb begin
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    rdy_d   = 1'b0;
    if (take_bit) begin
      shreg_d = {shreg_q[WORD_W-2:0], sdata_s};
      if (last_bit) begin
        cnt_d = '0;
        rdy_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      cnt_q       <= '0;
      shreg_q     <= '0;
      rdy_q       <= 1'b0;
    end else begin
      sclk_prev_q <= sclk_s;
      rdy_q       <= rdy_d;
      if (take_bit) begin
        cnt_q   <= cnt_d;
        shreg_q <= shreg_d;
      end
    end
  end

  assign word_o     = shreg_q;
  assign bit_cnt_o  = cnt_q;
  assign word_rdy_o = rdy_q;
endmodule

// File: rtl/srw_regbank.sv
module srw_regbank
  import srw_pkg::*;
#(
  parameter int unsigned WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  commit_req_t       req_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] cal_o [CAL_NUM],
  output logic              done_o
);
  logic              ctrl_en;
  logic [WORD_W-1:0] ctrl_q;
  logic              done_q;

  assign ctrl_en = req_i.commit & ~req_i.dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= req_i.commit;
      if (ctrl_en) ctrl_q <= word_i;
    end
  end

  for (genvar g = 0; g < CAL_NUM; g++) begin : g_cal
    logic              cal_en;
    logic [WORD_W-1:0] cal_q;
    assign cal_en = req_i.commit & req_i.dest & (req_i.sel == CAL_SEL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cal_q <= '0;
      else if (cal_en) cal_q <= word_i;
    end
    assign cal_o[g] = cal_q;
  end

  assign ctrl_o = ctrl_q;
  assign done_o = done_q;
endmodule

// File: rtl/serial_reg_write_port.sv
module serial_reg_write_port
  import srw_pkg::*;
#(
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(WORD_W + 1),
  localparam int unsigned PIN_W      = 4 + CAL_SEL_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_in,
  input  logic                 sdata_in,
  input  logic                 frame_n_in,
  input  logic                 dest_in,
  input  logic [CAL_SEL_W-1:0] cal_sel_in,
  output logic [WORD_W-1:0]    ctrl_reg_o,
  output logic [WORD_W-1:0]    cal_zero_o,
  output logic [WORD_W-1:0]    cal_full_o,
  output logic [WORD_W-1:0]    cal_spare_o,
  output logic                 wr_done_o
);
  localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << 2;

  logic [1:0]           rst_pipe_q;
  logic                 rst_sync_n;
  logic [PIN_W-1:0]     pins_raw, pins_s;
  logic                 sclk_s, sdata_s, frame_n_s, dest_s;
  logic [CAL_SEL_W-1:0] sel_s;
  logic [WORD_W-1:0]    word;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 commit;
  commit_req_t          req;
  logic [WORD_W-1:0]    cal_regs [CAL_NUM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  assign pins_raw = {cal_sel_in, dest_in, frame_n_in, sdata_in, sclk_in};

  srw_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign sclk_s    = pins_s[0];
  assign sdata_s   = pins_s[1];
  assign frame_n_s = pins_s[2];
  assign dest_s    = pins_s[3];
  assign sel_s     = pins_s[PIN_W-1:4];

  srw_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sclk_s     (sclk_s),
    .sdata_s    (sdata_s),
    .frame_n_s  (frame_n_s),
    .word_o     (word),
    .bit_cnt_o  (bit_cnt),
    .word_rdy_o (commit)
  );

  assign req.commit = commit;
  assign req.dest   = dest_s;
  assign req.sel    = sel_s;

  srw_regbank #(.WORD_W(WORD_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .req_i  (req),
    .word_i (word),
    .ctrl_o (ctrl_reg_o),
    .cal_o  (cal_regs),
    .done_o (wr_done_o)
  );

  assign cal_zero_o  = cal_regs[CAL_ZERO];
  assign cal_full_o  = cal_regs[CAL_FULL];
  assign cal_spare_o = cal_regs[CAL_SPARE];
endmodule

// File: rtl/srw_checker.sv
module srw_checker #(
  parameter int unsigned WORD_W = 24,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_n_s,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              commit,
  input logic              wr_done,
  input logic [WORD_W-1:0] ctrl,
  input logic [WORD_W-1:0] cz,
  input logic [WORD_W-1:0] cf,
  input logic [WORD_W-1:0] cs
);
  assert_cnt_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CNT_W'(WORD_W));

  assert_hold_paused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_s |=> $stable(bit_cnt));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  assert_commit_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> wr_done);

  assert_ctrl_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctrl) |-> wr_done);

  assert_cal_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(cz) || !$stable(cf) || !$stable(cs)) |-> wr_done);

  assert_single_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!$stable(ctrl), !$stable(cz), !$stable(cf), !$stable(cs)}) <= 1);
endmodule

bind serial_reg_write_port srw_checker #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .frame_n_s (frame_n_s),
  .bit_cnt   (bit_cnt),
  .commit    (commit),
  .wr_done   (wr_done_o),
  .ctrl      (ctrl_reg_o),
  .cz        (cal_zero_o),
  .cf        (cal_full_o),
  .cs        (cal_spare_o)
);

// File: tb/sim_serial_reg_write_port.sv
`timescale 1ns/1ps
module sim_serial_reg_write_port;
  localparam int W      = 24;
  localparam int SYNC   = 2;
  localparam int LAT    = SYNC + 2;
  localparam int HALF   = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sclk = 1'b0, sdata = 1'b0, frame_n = 1'b1, dest = 1'b0;
  logic [1:0]    sel = 2'd0;
  logic [W-1:0]  ctrl_o, cz_o, cf_o, cs_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  int done_at;
  int done_hits;
  bit finished = 1'b0;

  logic [W-1:0] exp_ctrl = '0;
  logic [W-1:0] exp_cal [3] = '{default: '0};

  always #4 clk = ~clk;

  serial_reg_write_port #(.WORD_W(W), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk), .sdata_in(sdata),
    .frame_n_in(frame_n), .dest_in(dest), .cal_sel_in(sel),
    .ctrl_reg_o(ctrl_o), .cal_zero_o(cz_o), .cal_full_o(cf_o),
    .cal_spare_o(cs_o), .wr_done_o(done_o)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic void model_commit(logic d, logic [1:0] s, logic [W-1:0] w);
    if (!d) exp_ctrl = w;
    else if (s != 2'd3) exp_cal[s] = w;
  endfunction

  task automatic check_all(string req);
    check({req, " ctrl"},  ctrl_o, exp_ctrl);
    check({req, " zero"},  cz_o,   exp_cal[0]);
    check({req, " full"},  cf_o,   exp_cal[1]);
    check({req, " spare"}, cs_o,   exp_cal[2]);
  endtask

  task automatic pulse_bit(logic b, bit flip);
    sdata = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    for (int n = 1; n <= HALF + 2; n++) begin
      @(negedge clk);
      if (done_o) begin
        done_hits++;
        if (done_at == 0) done_at = n;
      end
      if (flip && n == 3) sdata = ~b;
    end
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    if (done_o) done_hits++;
  endtask

  task automatic write_word(logic d, logic [1:0] s, logic [W-1:0] w,
                            int pause_at, int junk, bit flips);
    dest = d; sel = s;
    done_at = 0; done_hits = 0;
    @(negedge clk); frame_n = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pause_at > 0 && i == W - 1 - pause_at) begin
        frame_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int j = 0; j < junk; j++) pulse_bit(1'($urandom), 1'b0);
        frame_n = 1'b0;
        repeat (2) @(negedge clk);
      end
      pulse_bit(w[i], flips && ($urandom % 3 == 0) && i != 0);
    end
    frame_n = 1'b1;
    repeat (3) @(negedge clk);
    model_commit(d, s, w);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R1 during reset
    check_all("R1 in reset");
    check("R1 done in reset", W'(done_o), '0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_all("R1 after reset");

    // R2 MSB first, R3 control target, R8 latency
    write_word(1'b0, 2'd0, 24'h800001, 0, 0, 1'b0);
    check_all("R2 R3 msb-first control");
    check("R8 latency", W'(done_at), W'(LAT));
    check("R8 single pulse", W'(done_hits), W'(1));

    // R4 each calibration slot
    write_word(1'b1, 2'd0, 24'hA5_0F3C, 0, 0, 1'b0);
    write_word(1'b1, 2'd1, 24'h13_57_9B, 0, 0, 1'b0);
    write_word(1'b1, 2'd2, 24'hFE_DC_BA, 0, 0, 1'b0);
    check_all("R4 calibration slots");

    // R5 unused select discards but pulses
    write_word(1'b1, 2'd3, 24'h77_77_77, 0, 0, 1'b0);
    check_all("R5 unused select");
    check("R5 done pulse", W'(done_hits), W'(1));

    // R6 R7 pause with spurious edges
    write_word(1'b0, 2'd0, 24'h3C_96_E1, 11, 4, 1'b0);
    check_all("R6 R7 paused word");
    check("R7 latency after resume", W'(done_at), W'(LAT));

    // R7 pause right after first bit and before last
    write_word(1'b1, 2'd1, 24'hC0_FF_EE, 1, 2, 1'b0);
    write_word(1'b1, 2'd2, 24'h01_23_45, 23, 3, 1'b0);
    check_all("R7 edge pauses");

    // R10 late data change
    write_word(1'b0, 2'd0, 24'h5A_A5_5A, 0, 0, 1'b1);
    check_all("R10 late data change");

    // R9 back-to-back random words, random pauses
    for (int k = 0; k < 24; k++) begin
      logic         d = 1'($urandom);
      logic [1:0]   s = 2'($urandom);
      logic [W-1:0] w = W'($urandom);
      int           p = ($urandom % 2 == 0) ? 0 : 1 + ($urandom % (W - 1));
      write_word(d, s, w, p, $urandom % 4, 1'($urandom));
      check_all("R9 random word");
      check("R8 random pulse", W'(done_hits), W'(1));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule